// File: doc/BRIEF.md
# DVB-ASI Mode Lock Detector

This block decides whether the 10-bit stream coming out of an 8b/10b receive path should be treated as asynchronous serial transport data. For every received word it takes a valid strobe and two error indications from the decoder: a code error and a running-disparity error. From these it keeps a hysteresis state that is announced on `asi_mode`. A run of clean words is needed to enter the mode, and an equally long run of faulty words is needed to leave it, so isolated errors do not make the flag chatter.

Several conditions force the block out of the mode at once, whatever the counters hold. These are a pulse from the video path saying that SMPTE timing reference words were seen, a raised carrier-lost input, a raised bypass input, and a lowered enable input. While any of them is present, both run counters are held at zero. The block also flags the comma character K28.5 in the raw word, in either bit polarity.

The state machine has two states. ST_ACQUIRE counts consecutive clean words and moves to ST_LOCKED (transition T_LOCK) when the 32nd clean word is counted. ST_LOCKED counts consecutive faulty words and returns to ST_ACQUIRE (transition T_UNLOCK) when the 32nd faulty word is counted. Any forced-exit condition also returns it to ST_ACQUIRE (transition T_FORCE). `asi_mode` is high exactly in ST_LOCKED.

Top module: `asi_lock_detect`

## Requirements
- R1: After the active-low reset `rst_n`, `asi_mode` and `comma_hit` are 0.
- R2: In ST_ACQUIRE, `asi_mode` rises on the clock edge that samples the 32nd consecutive valid word that carries neither error flag.
- R3: A valid word with an error flag, seen in ST_ACQUIRE, sets the clean-word count back to zero, so 32 fresh clean words are needed afterwards.
- R4: In ST_LOCKED, `asi_mode` falls on the edge that samples the 32nd consecutive valid faulty word. A valid clean word in between sets the faulty-word count back to zero.
- R5: `trs_seen` high at a clock edge clears `asi_mode` at that edge and zeroes both counts.
- R6: `carrier_lost` high, `smpte_bypass` high or `asi_enable` low each clear `asi_mode` at the next edge. While the condition lasts, both counts stay at zero, so no number of clean words can enter the mode.
- R7: A word counts as faulty when `code_err` or `disp_err` is set. Either flag alone is enough.
- R8: A cycle with `word_vld` low neither advances nor resets either count, whatever the error flags show.
- R9: `comma_hit` is high in the cycle after a valid word equal to 10'b0011111010 (0x0FA) or its bitwise inverse 10'b1100000101 (0x305). It is low after any other word and after any invalid cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset, also a forced exit |
| word_vld | input | 1 | A received word is present this cycle |
| code_err | input | 1 | Decoder found an invalid code group |
| disp_err | input | 1 | Decoder found a running-disparity violation |
| trs_seen | input | 1 | Video path detected SMPTE timing reference words |
| carrier_lost | input | 1 | Carrier detect reports no signal (high = lost) |
| smpte_bypass | input | 1 | Bypass requested, disables ASI operation when high |
| asi_enable | input | 1 | ASI operation allowed when high |
| rx_word | input | 10 | Raw received 10-bit word |
| asi_mode | output | 1 | Stream is being treated as ASI |
| comma_hit | output | 1 | Previous valid word was K28.5 in either polarity |

## Verification
Clean runs of exactly 31 and 32 words show whether entry happens on the right word rather than one word early or late. A 31-word run broken by one error, followed by a fresh run, shows whether an error really restarts acquisition. Faulty runs built from code errors only, then disparity errors only, each broken by a single clean word, show that both flags count and that the exit run restarts. Invalid cycles carrying error flags, the TRS pulse, and each of the three control conditions held over long clean runs show the gating and the forced exits, and the comma words are tried in both polarities, with near misses and with the valid strobe low.

// File: rtl/asi_lock_pkg.sv
package asi_lock_pkg;

    typedef enum logic {
        ST_ACQUIRE = 1'b0,
        ST_LOCKED  = 1'b1
    } lock_state_t;

    localparam int WORD_W = 10;

endpackage

// File: rtl/asi_run_counter.sv
module asi_run_counter #(
    parameter  int LIMIT = 32,
    localparam int CW    = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic run_done
);

    logic [CW-1:0] run_cnt;

    // saturating run counter, clear wins over increment
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (clr) begin
            run_cnt <= '0;
        end else if (inc && (run_cnt != {CW{1'b1}})) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign run_done = inc && (run_cnt == CW'(LIMIT - 1));

endmodule

// File: rtl/asi_comma_match.sv
module asi_comma_match #(
    parameter int                 W         = 10,
    parameter logic [W-1:0]       PATTERN   = 10'b0011111010,
    parameter bit                 BOTH_POL  = 1'b1
) (
    input  logic [W-1:0] word,
    output logic         match
);

    generate
        if (BOTH_POL) begin : g_both
            assign match = (word == PATTERN) || (word == ~PATTERN);
        end else begin : g_one
            assign match = (word == PATTERN);
        end
    endgenerate

endmodule

// File: rtl/asi_lock_detect.sv
module asi_lock_detect
    import asi_lock_pkg::*;
#(
    parameter int RUN_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic              code_err,
    input  logic              disp_err,
    input  logic              trs_seen,
    input  logic              carrier_lost,
    input  logic              smpte_bypass,
    input  logic              asi_enable,
    input  logic [WORD_W-1:0] rx_word,
    output logic              asi_mode,
    output logic              comma_hit
);

    lock_state_t state_q, state_d;

    logic force_exit;
    logic word_bad;
    logic good_inc, good_clr, good_done;
    logic bad_inc,  bad_clr,  bad_done;
    logic comma_now;

    assign force_exit = trs_seen | carrier_lost | smpte_bypass | ~asi_enable;
    assign word_bad   = code_err | disp_err;

    // clean-word run, only meaningful while acquiring
    assign good_inc = word_vld & ~word_bad & ~force_exit & (state_q == ST_ACQUIRE);
    assign good_clr = force_exit | (state_q != ST_ACQUIRE) | (word_vld & word_bad) | good_done;

    // faulty-word run, only meaningful while locked
    assign bad_inc  = word_vld & word_bad & ~force_exit & (state_q == ST_LOCKED);
    assign bad_clr  = force_exit | (state_q != ST_LOCKED) | (word_vld & ~word_bad) | bad_done;

    asi_run_counter #(.LIMIT(RUN_LEN)) u_good_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (good_clr),
        .inc      (good_inc),
        .run_done (good_done)
    );

    asi_run_counter #(.LIMIT(RUN_LEN)) u_bad_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (bad_clr),
        .inc      (bad_inc),
        .run_done (bad_done)
    );

    asi_comma_match #(
        .W        (WORD_W),
        .PATTERN  (10'b0011111010),
        .BOTH_POL (1'b1)
    ) u_comma (
        .word  (rx_word),
        .match (comma_now)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (force_exit) begin
            state_d = ST_ACQUIRE;                 // T_FORCE
        end else begin
            unique case (state_q)
                ST_ACQUIRE: if (good_done) state_d = ST_LOCKED;  // T_LOCK
                ST_LOCKED:  if (bad_done)  state_d = ST_ACQUIRE; // T_UNLOCK
                default:    state_d = ST_ACQUIRE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ACQUIRE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        asi_mode = (state_q == ST_LOCKED);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            comma_hit <= 1'b0;
        end else begin
            comma_hit <= word_vld & comma_now;
        end
    end

endmodule

// File: rtl/asi_lock_chk.sv
module asi_lock_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       word_vld,
    input logic       code_err,
    input logic       disp_err,
    input logic       trs_seen,
    input logic       carrier_lost,
    input logic       smpte_bypass,
    input logic       asi_enable,
    input logic [9:0] rx_word,
    input logic       asi_mode,
    input logic       comma_hit
);

    logic forced;
    assign forced = trs_seen | carrier_lost | smpte_bypass | ~asi_enable;

    AST_TRS_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        trs_seen |=> !asi_mode); // R5

    AST_CTRL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (carrier_lost || smpte_bypass || !asi_enable) |=> !asi_mode); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_vld && !forced) |=> $stable(asi_mode)); // R8

    AST_CLEAN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (asi_mode && word_vld && !code_err && !disp_err && !forced) |=> asi_mode); // R4

    AST_ERR_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!asi_mode && word_vld && (code_err || disp_err)) |=> !asi_mode); // R3

    AST_RISE_ON_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asi_mode) |-> $past(word_vld && !code_err && !disp_err && !forced)); // R2

    AST_COMMA_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && (rx_word == 10'h0FA || rx_word == 10'h305)) |=> comma_hit); // R9

    AST_COMMA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |=> !comma_hit); // R9

endmodule

bind asi_lock_detect asi_lock_chk u_chk (.*);

// File: tb/sim_asi_lock_detect.sv
`timescale 1ns/1ps
module sim_asi_lock_detect;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       word_vld = 1'b0;
    logic       code_err = 1'b0;
    logic       disp_err = 1'b0;
    logic       trs_seen = 1'b0;
    logic       carrier_lost = 1'b0;
    logic       smpte_bypass = 1'b0;
    logic       asi_enable = 1'b1;
    logic [9:0] rx_word = 10'h000;
    logic       asi_mode;
    logic       comma_hit;

    int total = 0;
    int bad   = 0;

    // reference model state
    int  m_run  = 0;
    bit  m_mode = 1'b0;
    bit  m_comma = 1'b0;

    always #10 clk = ~clk;

    asi_lock_detect u0 (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .code_err(code_err),
        .disp_err(disp_err), .trs_seen(trs_seen), .carrier_lost(carrier_lost),
        .smpte_bypass(smpte_bypass), .asi_enable(asi_enable), .rx_word(rx_word),
        .asi_mode(asi_mode), .comma_hit(comma_hit)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // one word cycle: drive at falling edge, model at rising edge, compare after it
    task automatic cyc(input string tag, input bit v, input bit ce, input bit de,
                       input bit trs, input bit cd, input bit byp, input bit en,
                       input logic [9:0] w);
        bit frc;
        @(negedge clk);
        word_vld = v; code_err = ce; disp_err = de; trs_seen = trs;
        carrier_lost = cd; smpte_bypass = byp; asi_enable = en; rx_word = w;
        @(posedge clk);
        frc = trs || cd || byp || !en;
        if (frc) begin
            m_mode = 1'b0;
            m_run  = 0;
        end else if (v) begin
            if (!m_mode) begin
                if (ce || de) m_run = 0;
                else          m_run++;
                if (m_run == 32) begin m_mode = 1'b1; m_run = 0; end
            end else begin
                if (ce || de) m_run++;
                else          m_run = 0;
                if (m_run == 32) begin m_mode = 1'b0; m_run = 0; end
            end
        end
        m_comma = v && (w == 10'h0FA || w == 10'h305);
        #1;
        check(tag, asi_mode, m_mode);
        check("R9", comma_hit, m_comma);
    endtask

    task automatic clean(input string tag, input int n);
        for (int i = 0; i < n; i++) cyc(tag, 1, 0, 0, 0, 0, 0, 1, 10'h155);
    endtask

    task automatic faulty(input string tag, input int n, input bit ce, input bit de);
        for (int i = 0; i < n; i++) cyc(tag, 1, ce, de, 0, 0, 0, 1, 10'h2AA);
    endtask

    task automatic lock_up();
        clean("R2", 32);
        check("R2", asi_mode, 1'b1);
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1", asi_mode, 1'b0);
        check("R1", comma_hit, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 entry exactly on the 32nd clean word
        clean("R2", 31);
        check("R2", asi_mode, 1'b0);
        clean("R2", 1);
        check("R2", asi_mode, 1'b1);

        // R4/R7 exit: code errors broken by one clean word, then disparity only
        faulty("R7", 31, 1, 0);
        clean("R4", 1);
        check("R4", asi_mode, 1'b1);
        faulty("R7", 31, 0, 1);
        check("R4", asi_mode, 1'b1);
        faulty("R4", 1, 1, 1);
        check("R4", asi_mode, 1'b0);

        // R3 error restarts acquisition
        clean("R3", 31);
        faulty("R3", 1, 0, 1);
        clean("R3", 31);
        check("R3", asi_mode, 1'b0);
        clean("R3", 1);
        check("R3", asi_mode, 1'b1);

        // R8 invalid cycles with error flags do not disturb the faulty run
        faulty("R8", 20, 1, 0);
        for (int i = 0; i < 5; i++) cyc("R8", 0, 0, 0, 0, 0, 0, 1, 10'h000);
        faulty("R8", 11, 1, 0);
        check("R8", asi_mode, 1'b1);
        for (int i = 0; i < 5; i++) cyc("R8", 0, 1, 1, 0, 0, 0, 1, 10'h000);
        faulty("R8", 1, 1, 0);
        check("R8", asi_mode, 1'b0);
        // R8 gaps during acquisition
        clean("R8", 16);
        for (int i = 0; i < 4; i++) cyc("R8", 0, 1, 0, 0, 0, 0, 1, 10'h000);
        clean("R8", 16);
        check("R8", asi_mode, 1'b1);

        // R5 TRS forces exit and restarts counting
        cyc("R5", 1, 0, 0, 1, 0, 0, 1, 10'h155);
        check("R5", asi_mode, 1'b0);
        clean("R5", 31);
        check("R5", asi_mode, 1'b0);
        clean("R5", 1);
        check("R5", asi_mode, 1'b1);

        // R6 carrier lost, bypass, enable low, each held over long clean runs
        for (int i = 0; i < 40; i++) cyc("R6", 1, 0, 0, 0, 1, 0, 1, 10'h155);
        check("R6", asi_mode, 1'b0);
        lock_up();
        for (int i = 0; i < 40; i++) cyc("R6", 1, 0, 0, 0, 0, 1, 1, 10'h155);
        check("R6", asi_mode, 1'b0);
        lock_up();
        for (int i = 0; i < 40; i++) cyc("R6", 1, 0, 0, 0, 0, 0, 0, 10'h155);
        check("R6", asi_mode, 1'b0);
        clean("R6", 31);
        check("R6", asi_mode, 1'b0);

        // R9 comma in both polarities, near misses, invalid strobe
        cyc("R9", 1, 0, 0, 0, 0, 0, 1, 10'h0FA);
        check("R9", comma_hit, 1'b1);
        cyc("R9", 1, 0, 0, 0, 0, 0, 1, 10'h305);
        check("R9", comma_hit, 1'b1);
        cyc("R9", 1, 0, 0, 0, 0, 0, 1, 10'h0FB);
        check("R9", comma_hit, 1'b0);
        cyc("R9", 1, 0, 0, 0, 0, 0, 1, 10'h304);
        check("R9", comma_hit, 1'b0);
        cyc("R9", 0, 0, 0, 0, 0, 0, 1, 10'h0FA);
        check("R9", comma_hit, 1'b0);

        // R1 reset mid-lock
        clean("R1", 40);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", asi_mode, 1'b0);
        check("R1", comma_hit, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule